// File: doc/BRIEF.md
# Boot Table Stream Loader

This block turns a boot-table stream into writes on a program-memory port. Items arrive with a valid strobe, either as 16-bit words or as bytes on the low eight data bits. The first item decides how the rest of the stream is assembled. A leading 16-bit word of 10AAh selects word assembly. A leading byte of 08h followed by a byte of AAh selects byte assembly, in which each word is built from two bytes, most significant byte first.

After the keyword comes a header. Its shape depends on a layout input that is latched when the keyword is accepted. The parallel layout carries two live configuration words, a wait-state value and a bank-switch value. The serial layout carries four placeholder words, which are read and dropped. The header ends with a 23-bit entry address, sent as a page word and then an offset word.

Code sections follow the header. Each section gives a size, a destination page and a destination offset, and then that many code words, which are written to ascending addresses. A size of zero ends the table. The loader then raises done and presents the entry address until it is reset.

Top module: `bootstream_loader`

## Requirements
- R1: When the first valid item in keyword search equals 16'h10AA, the loader enters word assembly: every later valid item is one 16-bit table word.
- R2: When the first valid item in keyword search has 8'h08 in bits 7..0 and the next valid item has 8'hAA in bits 7..0, the loader enters byte assembly. Each table word is then {first byte, second byte}, with each byte taken from bits 7..0 of the data input and bits 15..8 ignored.
- R3: In parallel layout (`layout_ser`=0 at keyword acceptance), the first header word appears on `ws_val` with a one-cycle `ws_load` pulse. The second header word then appears on `bank_val` with a one-cycle `bank_load` pulse. Each pulse comes in the cycle after the word's final input beat.
- R4: In serial layout (`layout_ser`=1), the four words after the keyword are consumed without any `ws_load`, `bank_load` or write.
- R5: The header then carries an entry page word, of which only bits 6..0 are used as address bits 22..16, and an entry offset word, which gives bits 15..0. Once done is high, `entry_addr` shows this 23-bit address.
- R6: Each section consists of a size word N, a page word (bits 6..0 used as address bits 22..16), an offset word, and N code words. The code words are written to the destination and to the addresses that follow it in ascending order, with a carry from the offset into the page.
- R7: A section size of 0000h sets `done`. `done` stays high, and all further input produces no write and no load pulse, until reset.
- R8: A rejected keyword sets `err` high for one cycle, in the cycle after the offending item, and the loader returns to keyword search. A rejected keyword is either a first item that is neither 10AAh nor has a low byte of 08h, or a second byte other than AAh. No write occurs on the way.
- R9: `wr_en` is high for exactly one cycle, the cycle after the final input beat of each code word, with `wr_addr` and `wr_data` valid in that cycle. Cycles without `in_valid` produce no writes.
- R10: A synchronous `rst` at any point, including in the middle of a table, clears `done` and `err` and returns the loader to keyword search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| layout_ser | input | 1 | Header layout: 0 parallel, 1 serial; sampled at keyword acceptance |
| in_valid | input | 1 | Stream item valid |
| in_data | input | 16 | Stream item; bytes use bits 7..0 |
| wr_en | output | 1 | Program-memory write strobe |
| wr_addr | output | 23 | Write address |
| wr_data | output | 16 | Write data |
| ws_val | output | 16 | Captured wait-state configuration |
| ws_load | output | 1 | One-cycle pulse when `ws_val` is updated |
| bank_val | output | 16 | Captured bank-switch configuration |
| bank_load | output | 1 | One-cycle pulse when `bank_val` is updated |
| done | output | 1 | Table finished; held until reset |
| err | output | 1 | One-cycle pulse on a rejected keyword |
| entry_addr | output | 23 | Entry address, valid while `done` is high |

## Verification
The bench places one section across an offset boundary of FFFFh, so a loader that did not carry into the page would write the wrong addresses. Page words have bits above bit 6 set, which catches a loader that leaks them into the address. The serial-layout run uses placeholders that look like a keyword or a configuration value, which exposes a design that pulses loads on them. Byte bits 15..8 carry junk, and gaps of idle cycles are put between bytes, which catches wrong byte ordering or assembly that runs while valid is low.

Both forms of bad keyword are sent, followed by a good table, which catches a loader that stalls, writes, or fails to recover after an error. A reset in the middle of a table is also exercised. Words sent after the end marker would turn up as unexpected scoreboard writes if the loader kept running.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

   typedef enum logic [3:0] {
      S_KEY,
      S_KEY2,
      S_HDR,
      S_EPAGE,
      S_EOFF,
      S_SSIZE,
      S_SPAGE,
      S_SOFF,
      S_CODE,
      S_DONE
   } bsl_state_t;

   localparam int HDR_PAR_WORDS = 2;

endpackage

// File: rtl/bsl_word_asm.sv
module bsl_word_asm #(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              wide,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              w_valid,
   output logic [WORD_W-1:0] w_data
);

   logic              phase_q;
   logic [BYTE_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= 1'b0;
         hi_q    <= '0;
      end else if (clr || wide) begin
         phase_q <= 1'b0;
      end else if (in_valid) begin
         if (!phase_q) begin
            hi_q    <= in_data[BYTE_W-1:0];
            phase_q <= 1'b1;
         end else begin
            phase_q <= 1'b0;
         end
      end
   end

   always_comb begin
      if (clr) begin
         w_valid = 1'b0;
         w_data  = in_data;
      end else if (wide) begin
         w_valid = in_valid;
         w_data  = in_data;
      end else begin
         w_valid = in_valid && phase_q;
         w_data  = {hi_q, in_data[BYTE_W-1:0]};
      end
   end

endmodule

// File: rtl/bsl_addr_gen.sv
module bsl_addr_gen #(
   parameter int WORD_W = 16,
   parameter int PAGE_W = 7,
   parameter int OFF_W  = 16,
   localparam int ADDR_W = PAGE_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_page,
   input  logic              ld_off,
   input  logic              inc,
   input  logic [WORD_W-1:0] din,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
      end else if (ld_page) begin
         addr_q[ADDR_W-1:OFF_W] <= din[PAGE_W-1:0];
      end else if (ld_off) begin
         addr_q[OFF_W-1:0] <= din[OFF_W-1:0];
      end else if (inc) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   assign addr = addr_q;

endmodule

// File: rtl/bsl_seq.sv
module bsl_seq
   import bsl_pkg::*;
#(
   parameter int              BYTE_W   = 8,
   parameter int              WORD_W   = 16,
   parameter int              PAGE_W   = 7,
   parameter int              OFF_W    = 16,
   parameter int              HDR_SER  = 4,
   parameter logic [WORD_W-1:0] KEY_WIDE = 16'h10AA,
   parameter logic [BYTE_W-1:0] KEY_B0  = 8'h08,
   parameter logic [BYTE_W-1:0] KEY_B1  = 8'hAA,
   localparam int ADDR_W  = PAGE_W + OFF_W,
   localparam int HDR_MAX = (HDR_SER > HDR_PAR_WORDS) ? HDR_SER : HDR_PAR_WORDS,
   localparam int HCNT_W  = $clog2(HDR_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              layout_ser,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   input  logic              w_valid,
   input  logic [WORD_W-1:0] w_data,
   output logic              asm_clr,
   output logic              asm_wide,
   output logic              ag_ld_page,
   output logic              ag_ld_off,
   output logic              wr_req,
   output logic [WORD_W-1:0] ws_val,
   output logic              ws_load,
   output logic [WORD_W-1:0] bank_val,
   output logic              bank_load,
   output logic              done,
   output logic              err,
   output logic [ADDR_W-1:0] entry_addr
);

   bsl_state_t        state_q;
   logic              wide_q;
   logic              ser_q;
   logic [HCNT_W-1:0] hcnt_q;
   logic [HCNT_W-1:0] hdr_last;
   logic [WORD_W-1:0] remain_q;
   logic [PAGE_W-1:0] epage_q;
   logic [OFF_W-1:0]  eoff_q;

   assign hdr_last = ser_q ? HCNT_W'(HDR_SER - 1) : HCNT_W'(HDR_PAR_WORDS - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= S_KEY;
         wide_q    <= 1'b0;
         ser_q     <= 1'b0;
         hcnt_q    <= '0;
         remain_q  <= '0;
         epage_q   <= '0;
         eoff_q    <= '0;
         ws_val    <= '0;
         bank_val  <= '0;
         ws_load   <= 1'b0;
         bank_load <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
      end else begin
         ws_load   <= 1'b0;
         bank_load <= 1'b0;
         err       <= 1'b0;
         unique case (state_q)
            S_KEY: begin
               if (in_valid) begin
                  if (in_data == KEY_WIDE) begin
                     wide_q  <= 1'b1;
                     ser_q   <= layout_ser;
                     hcnt_q  <= '0;
                     state_q <= S_HDR;
                  end else if (in_data[BYTE_W-1:0] == KEY_B0) begin
                     state_q <= S_KEY2;
                  end else begin
                     err <= 1'b1;
                  end
               end
            end
            S_KEY2: begin
               if (in_valid) begin
                  if (in_data[BYTE_W-1:0] == KEY_B1) begin
                     wide_q  <= 1'b0;
                     ser_q   <= layout_ser;
                     hcnt_q  <= '0;
                     state_q <= S_HDR;
                  end else begin
                     err     <= 1'b1;
                     state_q <= S_KEY;
                  end
               end
            end
            S_HDR: begin
               if (w_valid) begin
                  if (!ser_q) begin
                     if (hcnt_q == '0) begin
                        ws_val  <= w_data;
                        ws_load <= 1'b1;
                     end else begin
                        bank_val  <= w_data;
                        bank_load <= 1'b1;
                     end
                  end
                  hcnt_q <= hcnt_q + 1'b1;
                  if (hcnt_q == hdr_last) state_q <= S_EPAGE;
               end
            end
            S_EPAGE: begin
               if (w_valid) begin
                  epage_q <= w_data[PAGE_W-1:0];
                  state_q <= S_EOFF;
               end
            end
            S_EOFF: begin
               if (w_valid) begin
                  eoff_q  <= w_data[OFF_W-1:0];
                  state_q <= S_SSIZE;
               end
            end
            S_SSIZE: begin
               if (w_valid) begin
                  if (w_data == '0) begin
                     done    <= 1'b1;
                     state_q <= S_DONE;
                  end else begin
                     remain_q <= w_data;
                     state_q  <= S_SPAGE;
                  end
               end
            end
            S_SPAGE: if (w_valid) state_q <= S_SOFF;
            S_SOFF:  if (w_valid) state_q <= S_CODE;
            S_CODE: begin
               if (w_valid) begin
                  remain_q <= remain_q - 1'b1;
                  if (remain_q == WORD_W'(1)) state_q <= S_SSIZE;
               end
            end
            S_DONE: state_q <= S_DONE;
            default: state_q <= S_KEY;
         endcase
      end
   end

   assign asm_clr    = (state_q == S_KEY) || (state_q == S_KEY2) || (state_q == S_DONE);
   assign asm_wide   = wide_q;
   assign ag_ld_page = (state_q == S_SPAGE) && w_valid;
   assign ag_ld_off  = (state_q == S_SOFF) && w_valid;
   assign wr_req     = (state_q == S_CODE) && w_valid;
   assign entry_addr = {epage_q, eoff_q};

endmodule

// File: rtl/bootstream_loader.sv
module bootstream_loader #(
   parameter int          BYTE_W   = 8,
   parameter int          WORD_W   = 16,
   parameter int          PAGE_W   = 7,
   parameter int          OFF_W    = 16,
   parameter int          HDR_SER  = 4,
   parameter bit          WR_REG   = 1'b1,
   parameter logic [15:0] KEY_WIDE = 16'h10AA,
   parameter logic [7:0]  KEY_B0   = 8'h08,
   parameter logic [7:0]  KEY_B1   = 8'hAA,
   localparam int ADDR_W = PAGE_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              layout_ser,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] ws_val,
   output logic              ws_load,
   output logic [WORD_W-1:0] bank_val,
   output logic              bank_load,
   output logic              done,
   output logic              err,
   output logic [ADDR_W-1:0] entry_addr
);

   if (WORD_W != 2 * BYTE_W) begin : g_bad_word
      $error("WORD_W must be twice BYTE_W");
   end
   if (PAGE_W > WORD_W || OFF_W > WORD_W) begin : g_bad_addr
      $error("address fields must fit in one word");
   end
   if (HDR_SER < 1) begin : g_bad_hdr
      $error("HDR_SER must be at least one");
   end

   logic              w_valid;
   logic [WORD_W-1:0] w_data;
   logic              asm_clr;
   logic              asm_wide;
   logic              ag_ld_page;
   logic              ag_ld_off;
   logic              wr_req;
   logic [ADDR_W-1:0] cur_addr;

   bsl_word_asm #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_asm (
      .clk      (clk),
      .rst      (rst),
      .clr      (asm_clr),
      .wide     (asm_wide),
      .in_valid (in_valid),
      .in_data  (in_data),
      .w_valid  (w_valid),
      .w_data   (w_data)
   );

   bsl_seq #(
      .BYTE_W   (BYTE_W),
      .WORD_W   (WORD_W),
      .PAGE_W   (PAGE_W),
      .OFF_W    (OFF_W),
      .HDR_SER  (HDR_SER),
      .KEY_WIDE (KEY_WIDE[WORD_W-1:0]),
      .KEY_B0   (KEY_B0[BYTE_W-1:0]),
      .KEY_B1   (KEY_B1[BYTE_W-1:0])
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .layout_ser (layout_ser),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .w_valid    (w_valid),
      .w_data     (w_data),
      .asm_clr    (asm_clr),
      .asm_wide   (asm_wide),
      .ag_ld_page (ag_ld_page),
      .ag_ld_off  (ag_ld_off),
      .wr_req     (wr_req),
      .ws_val     (ws_val),
      .ws_load    (ws_load),
      .bank_val   (bank_val),
      .bank_load  (bank_load),
      .done       (done),
      .err        (err),
      .entry_addr (entry_addr)
   );

   bsl_addr_gen #(.WORD_W(WORD_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_addr (
      .clk     (clk),
      .rst     (rst),
      .ld_page (ag_ld_page),
      .ld_off  (ag_ld_off),
      .inc     (wr_req),
      .din     (w_data),
      .addr    (cur_addr)
   );

   if (WR_REG) begin : g_wr_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
         end else begin
            wr_en   <= wr_req;
            wr_addr <= cur_addr;
            wr_data <= w_data;
         end
      end
   end else begin : g_wr_comb
      assign wr_en   = wr_req;
      assign wr_addr = cur_addr;
      assign wr_data = w_data;
   end

endmodule

// File: rtl/bootstream_loader_chk.sv
module bootstream_loader_chk #(
   parameter bit WR_REG = 1'b1,
   parameter int ADDR_W = 23,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              ws_load,
   input logic              bank_load,
   input logic              done,
   input logic              err
);

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
      done |=> done); // R7

   AST_NO_WR_DONE: assert property (@(posedge clk) disable iff (rst)
      done |-> !wr_en); // R7

   AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      err |-> (!wr_en && !done)); // R8

   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ws_load, bank_load, wr_en})); // R3

   AST_WR_ASCEND: assert property (@(posedge clk) disable iff (rst)
      (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1))); // R6

   if (WR_REG) begin : g_reg
      AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
         wr_en |-> $past(in_valid)); // R9
   end else begin : g_comb
      AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
         wr_en |-> in_valid); // R9
   end

endmodule

bind bootstream_loader bootstream_loader_chk #(
   .WR_REG (WR_REG),
   .ADDR_W (ADDR_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .ws_load   (ws_load),
   .bank_load (bank_load),
   .done      (done),
   .err       (err)
);

// File: tb/bootstream_loader_tb.sv
`timescale 1ns/1ps
module bootstream_loader_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        layout_ser = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        wr_en;
   logic [22:0] wr_addr;
   logic [15:0] wr_data;
   logic [15:0] ws_val;
   logic        ws_load;
   logic [15:0] bank_val;
   logic        bank_load;
   logic        done;
   logic        err;
   logic [22:0] entry_addr;

   always #10 clk = ~clk;

   bootstream_loader u_dut (
      .clk        (clk),
      .rst        (rst),
      .layout_ser (layout_ser),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .ws_val     (ws_val),
      .ws_load    (ws_load),
      .bank_val   (bank_val),
      .bank_load  (bank_load),
      .done       (done),
      .err        (err),
      .entry_addr (entry_addr)
   );

   typedef struct {
      int          kind;
      logic [22:0] addr;
      logic [15:0] data;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   int   cyc    = 0;
   bit   narrow = 1'b0;
   int   gap    = 0;
   bit   finished = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic sb_pop(input int kind, input logic [22:0] a, input logic [15:0] d, input string tag);
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
         errors++;
         $display("FAIL %s unexpected event kind=%0d actual addr=%h data=%h expected none", tag, kind, a, d);
      end else begin
         e = exp_q.pop_front();
         if (e.kind != kind || e.addr != a || e.data != d) begin
            errors++;
            $display("FAIL %s actual kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
                     tag, kind, a, d, e.kind, e.addr, e.data);
         end
      end
   endtask

   // monitor: outputs are stable at the falling edge
   always @(negedge clk) begin
      if (!rst) begin
         if (ws_load)   sb_pop(1, '0, ws_val, "R3 ws");
         if (bank_load) sb_pop(2, '0, bank_val, "R3 bank");
         if (wr_en)     sb_pop(0, wr_addr, wr_data, "R6/R9 write");
      end
   end

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc == 150000 && !finished) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic push(input int kind, input logic [22:0] a, input logic [15:0] d);
      exp_t e;
      e.kind = kind; e.addr = a; e.data = d;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put(input logic [15:0] v);
      in_valid = 1'b1;
      in_data  = v;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'hDEAD;
      if (gap > 0) idle(gap);
   endtask

   task automatic put_byte(input logic [7:0] b);
      put({8'hC3, b});   // upper bits carry junk
   endtask

   task automatic send_word(input logic [15:0] w);
      if (narrow) begin
         put_byte(w[15:8]);
         put_byte(w[7:0]);
      end else begin
         put(w);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      idle(2);
      rst = 1'b0;
   endtask

   task automatic keyword();
      if (narrow) begin
         put_byte(8'h08);
         put_byte(8'hAA);
      end else begin
         put(16'h10AA);
      end
   endtask

   task automatic header(input bit ser, input logic [15:0] ws, input logic [15:0] bank,
                         input logic [15:0] ep, input logic [15:0] eo);
      layout_ser = ser;
      keyword();
      if (!ser) begin
         push(1, '0, ws);   send_word(ws);
         push(2, '0, bank); send_word(bank);
      end else begin
         send_word(16'h10AA);
         send_word(ws);
         send_word(bank);
         send_word(16'h0000);
      end
      send_word(ep);
      send_word(eo);
   endtask

   task automatic section(input logic [15:0] pg, input logic [15:0] off, input int n, input logic [15:0] seed);
      logic [22:0] base;
      base = {pg[6:0], off};
      send_word(16'(n));
      send_word(pg);
      send_word(off);
      for (int i = 0; i < n; i++) begin
         logic [15:0] d;
         d = seed + 16'(i * 3);
         push(0, base + 23'(i), d);
         send_word(d);
      end
   endtask

   task automatic finish_table(input logic [22:0] exp_entry, input string tag);
      send_word(16'h0000);
      check(done === 1'b1, {tag, " R7 done"}, {31'd0, done}, 32'd1);
      check(entry_addr === exp_entry, {tag, " R5 entry"}, {9'd0, entry_addr}, {9'd0, exp_entry});
      check(exp_q.size() == 0, {tag, " R6 all writes seen"}, exp_q.size(), 0);
   endtask

   initial begin
      idle(3);
      rst = 1'b0;
      // R10: reset state
      check(done === 1'b0, "R10 reset done", {31'd0, done}, 0);
      check(err === 1'b0, "R10 reset err", {31'd0, err}, 0);
      check(wr_en === 1'b0, "R10 reset wr_en", {31'd0, wr_en}, 0);

      // R1 R3 R5 R6: word assembly, parallel layout, carry across offset
      narrow = 1'b0; gap = 0;
      header(1'b0, 16'h1234, 16'h00A5, 16'h0081, 16'h4000);
      section(16'h0082, 16'hFFFF, 3, 16'h5000);
      section(16'h007F, 16'h0100, 1, 16'hBEEF);
      finish_table(23'h014000, "T1");

      // R7: further input ignored after done
      send_word(16'h0002);
      send_word(16'h0001);
      send_word(16'h0000);
      send_word(16'h7777);
      idle(2);
      check(done === 1'b1, "R7 done held", {31'd0, done}, 1);
      check(exp_q.size() == 0, "R7 no events after done", exp_q.size(), 0);

      // R10: reset clears done
      do_reset();
      check(done === 1'b0, "R10 done cleared", {31'd0, done}, 0);

      // R2 R4 R9: byte assembly, serial layout, idle gaps between bytes
      narrow = 1'b1; gap = 2;
      header(1'b1, 16'hAAAA, 16'h5555, 16'h0005, 16'h1234);
      section(16'h0010, 16'h0000, 2, 16'h0102);
      finish_table(23'h051234, "T2");

      // R8: bad keywords, then recovery
      do_reset();
      narrow = 1'b0; gap = 0;
      put(16'h1234);
      check(err === 1'b1, "R8 bad first item err", {31'd0, err}, 1);
      idle(1);
      check(err === 1'b0, "R8 err is a pulse", {31'd0, err}, 0);
      put(16'h0008);
      check(err === 1'b0, "R8 first byte accepted", {31'd0, err}, 0);
      put(16'h0055);
      check(err === 1'b1, "R8 bad second byte err", {31'd0, err}, 1);
      idle(1);
      check(done === 1'b0 && exp_q.size() == 0, "R8 no effects", {31'd0, done}, 0);

      // R2 R3: byte assembly with parallel layout after recovery
      narrow = 1'b1; gap = 1;
      header(1'b0, 16'h0F0E, 16'hC001, 16'h00FF, 16'h0010);
      section(16'h0003, 16'h8000, 3, 16'hA0A0);
      finish_table(23'h7F0010, "T3");

      // R10: reset in the middle of a table
      do_reset();
      narrow = 1'b0; gap = 0;
      layout_ser = 1'b0;
      put(16'h10AA);
      push(1, '0, 16'h4321);
      send_word(16'h4321);
      do_reset();
      check(done === 1'b0 && err === 1'b0, "R10 mid-table reset", {30'd0, done, err}, 0);
      // R1 R4: word assembly with serial layout from a fresh start
      header(1'b1, 16'h1111, 16'h2222, 16'h0000, 16'h0001);
      section(16'h0000, 16'h0200, 4, 16'h0010);
      finish_table(23'h000001, "T4");

      idle(3);
      check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule